// File: doc/BRIEF.md
# Credit-Throttled Bitstream Data Sink

This block accepts configuration bitstream dwords that a host pushes as memory writes into a data window, stores them in a buffer that holds a whole number of pages, and passes them in order to a downstream configuration engine over a 32-bit valid/ready stream. The host does not see per-beat back-pressure. Instead, the block gives the host one credit each time a full page of buffer space (1024 dwords, 4 KB, by default) is free. The host polls a running credit total, and it may write one page of data for each credit.

Transfer mode is on while both the transfer-start control and the configuration control are high. When both are low (teardown), the buffer is flushed and the credit total and the error flags clear. Two sticky flags report failures. A protocol error marks a write that was dropped because its byte enables were partial or because no credit was open. A starvation failure marks a page that did not complete within the timeout window after its credit was granted.

Top module: `credit_sink`

## Requirements
- R1: While transfer mode is on, no credit is open, no starvation failure is flagged and at least PAGE_DWORDS entries of the buffer are free, the block grants a credit. The running total rises by exactly one, and the first credit is visible within two cycles of transfer mode turning on.
- R2: `credit_reg` carries the low 8 bits of the running credit total in bits [15:8]. Bits [31:16] and [7:0] are always zero. The total wraps modulo 256 in that field, so 257 grants read as 0x01.
- R3: A credit stays open until PAGE_DWORDS dwords have been accepted. Only then, and only once a whole page of buffer space is free, is the next credit granted. With BUF_PAGES pages of buffer and a stalled consumer, the host can receive at most BUF_PAGES credits, and one more follows after a page has drained downstream.
- R4: Accepted dwords leave on `m_data` in arrival order. While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` hold.
- R5: A write counts as bitstream data only if it is a memory write (`wr_is_mem`=1) whose address lies in the window whose upper bits, from bit BAR_LOG2 up, match BAR_BASE. Configuration writes and writes outside the window are ignored and raise no error.
- R6: A data write inside the window with `wr_be` other than 4'hF, or sent while no credit is open, is dropped and sets the sticky `err_proto`.
- R7: `data_reg` reads 0x00000000 after reset and afterwards holds the last accepted dword.
- R8: If a granted page is not complete within TIMEOUT_MS milliseconds (counted with a CLK_HZ/1000 prescaler), `err_timeout` sets and stays set, the open credit is withdrawn, and no further credit is granted until teardown.
- R9: Teardown (`xfer_start`=0 and `cfg_mode`=0) clears the credit total, both error flags and the buffer on the next edge, as reset does.
- R10: While transfer mode is off, writes are ignored: no data is accepted, no credit is granted and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Transfer-start control |
| cfg_mode | input | 1 | Configuration-mode control |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_is_mem | input | 1 | 1 = memory write, 0 = configuration write |
| wr_addr | input | ADDR_W | Write byte address |
| wr_be | input | 4 | Write byte enables |
| wr_data | input | 32 | Write data dword |
| m_valid | output | 1 | Stream data valid |
| m_ready | input | 1 | Stream consumer ready |
| m_data | output | 32 | Stream data dword |
| credit_reg | output | 32 | Credit register image, total in bits [15:8] |
| data_reg | output | 32 | Last accepted data dword |
| err_proto | output | 1 | Sticky dropped-write error |
| err_timeout | output | 1 | Sticky starvation failure |

## Verification
Each bad internal state shows up at the ports within a few cycles. A page counter that is off by one moves the credit step in `credit_reg` by exactly one write, one edge after the page ends. A leak in the credit gate shows as a third credit while the consumer is stalled, and the buffer-room assertion fires in the same cycle as the overflowing write. A pointer or count error reorders or drops dwords on `m_data` as soon as the buffer drains. A wrong prescaler moves the rise of `err_timeout` away from the cycle set by CLK_HZ and TIMEOUT_MS, which the bench brackets on both sides.

// File: rtl/bsink_pkg.sv
package bsink_pkg;

  localparam logic [3:0] BE_ALL = 4'hF;

  // clock cycles per millisecond, never below one
  function automatic int unsigned cycles_per_ms(input int unsigned clk_hz);
    return (clk_hz < 1000) ? 1 : clk_hz / 1000;
  endfunction

  // credit register image from the running total
  function automatic logic [31:0] credit_word(input logic [7:0] total);
    return {16'h0000, total, 8'h00};
  endfunction

  // address window match on the bits above log2sz
  function automatic logic in_window(input logic [63:0] addr,
                                     input logic [63:0] base,
                                     input int unsigned log2sz);
    return (addr >> log2sz) == (base >> log2sz);
  endfunction

endpackage

// File: rtl/bsink_page_buf.sv
module bsink_page_buf #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 2048
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          push,
  input  logic [WIDTH-1:0]              push_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [WIDTH-1:0]              out_data,
  output logic [$clog2(DEPTH+1)-1:0]    free_cnt
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    fill;
  logic             pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign out_valid = (fill != '0);
  assign out_data  = mem[rd_ptr];
  assign pop       = out_valid && out_ready;
  assign free_cnt  = CW'(DEPTH) - fill;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

endmodule

// File: rtl/bsink_credit_ctrl.sv
module bsink_credit_ctrl #(
  parameter int unsigned PAGE_DWORDS = 1024,
  parameter int unsigned FREE_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              teardown,
  input  logic              accept,
  input  logic              revoke,
  input  logic              stall,
  input  logic [FREE_W-1:0] free_cnt,
  output logic              open,
  output logic              grant,
  output logic              page_done,
  output logic [7:0]        credit_total
);
  localparam int unsigned RX_W = $clog2(PAGE_DWORDS + 1);

  logic [RX_W-1:0] rx_cnt;

  assign grant     = active && !open && !stall &&
                     (free_cnt >= FREE_W'(PAGE_DWORDS));
  assign page_done = accept && (rx_cnt == RX_W'(PAGE_DWORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || teardown) begin
      open         <= 1'b0;
      rx_cnt       <= '0;
      credit_total <= '0;
    end else if (revoke) begin
      open <= 1'b0;
    end else if (grant) begin
      open         <= 1'b1;
      rx_cnt       <= '0;
      credit_total <= credit_total + 8'd1;
    end else if (accept) begin
      rx_cnt <= rx_cnt + RX_W'(1);
      if (page_done) open <= 1'b0;
    end
  end

endmodule

// File: rtl/bsink_starve_timer.sv
module bsink_starve_timer
  import bsink_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 125_000_000,
  parameter int unsigned TIMEOUT_MS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic arm,
  input  logic disarm,
  output logic expired
);
  localparam int unsigned PRE  = cycles_per_ms(CLK_HZ);
  localparam int unsigned PRE_W = $clog2(PRE + 1);
  localparam int unsigned MS_W  = $clog2(TIMEOUT_MS + 1);

  logic             armed;
  logic [PRE_W-1:0] pre;
  logic [MS_W-1:0]  ms;
  logic             tick;

  assign tick    = armed && (pre == PRE_W'(PRE - 1));
  assign expired = tick && (ms == MS_W'(TIMEOUT_MS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      armed <= 1'b0;
      pre   <= '0;
      ms    <= '0;
    end else if (arm) begin
      armed <= 1'b1;
      pre   <= '0;
      ms    <= '0;
    end else if (disarm) begin
      armed <= 1'b0;
    end else if (armed) begin
      if (tick) begin
        pre <= '0;
        ms  <= ms + MS_W'(1);
        if (expired) armed <= 1'b0;
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end

endmodule

// File: rtl/credit_sink.sv
module credit_sink
  import bsink_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter logic [63:0] BAR_BASE    = 64'h0000_0000_8000_0000,
  parameter int unsigned BAR_LOG2    = 20,
  parameter int unsigned PAGE_DWORDS = 1024,
  parameter int unsigned BUF_PAGES   = 2,
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned TIMEOUT_MS  = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              cfg_mode,
  input  logic              wr_en,
  input  logic              wr_is_mem,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [31:0]       m_data,
  output logic [31:0]       credit_reg,
  output logic [31:0]       data_reg,
  output logic              err_proto,
  output logic              err_timeout
);
  localparam int unsigned DEPTH  = PAGE_DWORDS * BUF_PAGES;
  localparam int unsigned FREE_W = $clog2(DEPTH + 1);

  // named internal events
  logic              active, teardown, in_win, hit, bad_wr, accept;
  logic              open, grant, page_done, expired;
  logic [7:0]        credit_total;
  logic [FREE_W-1:0] free_cnt;

  assign active   = xfer_start && cfg_mode;
  assign teardown = !xfer_start && !cfg_mode;

  generate
    if (BAR_LOG2 >= ADDR_W) begin : g_whole_space
      assign in_win = 1'b1;
    end else begin : g_window
      assign in_win = in_window(64'(wr_addr), BAR_BASE, BAR_LOG2);
    end
  endgenerate

  assign hit    = wr_en && wr_is_mem && in_win && active;
  assign bad_wr = hit && ((wr_be != BE_ALL) || !open);
  assign accept = hit && !bad_wr;

  bsink_page_buf #(.WIDTH(32), .DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (teardown),
    .push      (accept),
    .push_data (wr_data),
    .out_valid (m_valid),
    .out_ready (m_ready),
    .out_data  (m_data),
    .free_cnt  (free_cnt)
  );

  bsink_credit_ctrl #(.PAGE_DWORDS(PAGE_DWORDS), .FREE_W(FREE_W)) u_credit (
    .clk          (clk),
    .rst_n        (rst_n),
    .active       (active),
    .teardown     (teardown),
    .accept       (accept),
    .revoke       (expired),
    .stall        (err_timeout),
    .free_cnt     (free_cnt),
    .open         (open),
    .grant        (grant),
    .page_done    (page_done),
    .credit_total (credit_total)
  );

  bsink_starve_timer #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TIMEOUT_MS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (teardown),
    .arm     (grant),
    .disarm  (page_done),
    .expired (expired)
  );

  assign credit_reg = credit_word(credit_total);

  always_ff @(posedge clk) begin
    if (!rst_n) data_reg <= '0;
    else if (accept) data_reg <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || teardown) begin
      err_proto   <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      if (bad_wr)  err_proto   <= 1'b1;
      if (expired) err_timeout <= 1'b1;
    end
  end

endmodule

// File: rtl/credit_sink_chk.sv
module credit_sink_chk #(
  parameter int unsigned FREE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              teardown,
  input logic              grant,
  input logic              accept,
  input logic [FREE_W-1:0] free_cnt,
  input logic              m_valid,
  input logic              m_ready,
  input logic [31:0]       m_data,
  input logic [31:0]       credit_reg,
  input logic              err_proto,
  input logic              err_timeout
);

  // R1
  credit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> credit_reg[15:8] == $past(credit_reg[15:8]) + 8'd1);

  // R2
  credit_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    credit_reg[31:16] == 16'h0 && credit_reg[7:0] == 8'h0);

  // R3
  buf_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> free_cnt != '0);

  // R4
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !teardown) |=> (m_valid && $stable(m_data)));

  // R6
  proto_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_proto && !teardown) |=> err_proto);

  // R8
  starve_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_timeout && !teardown) |=> (err_timeout && !grant));

  // R9
  teardown_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    teardown |=> (credit_reg == 32'h0 && !err_proto && !err_timeout && !m_valid));

endmodule

bind credit_sink credit_sink_chk #(.FREE_W(FREE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .teardown    (teardown),
  .grant       (grant),
  .accept      (accept),
  .free_cnt    (free_cnt),
  .m_valid     (m_valid),
  .m_ready     (m_ready),
  .m_data      (m_data),
  .credit_reg  (credit_reg),
  .err_proto   (err_proto),
  .err_timeout (err_timeout)
);

// File: tb/test_credit_sink.sv
module test_credit_sink;
  localparam int unsigned PAGE = 8;
  localparam int unsigned PAGES = 2;
  localparam int unsigned CLKHZ = 4000;   // 4 cycles per ms
  localparam int unsigned TMO_MS = 50;    // 200 cycles
  localparam logic [31:0] IN_A  = 32'h8000_0010;
  localparam logic [31:0] OUT_A = 32'h4000_0010;

  logic clk = 0, rst_n = 0;
  logic xfer_start = 0, cfg_mode = 0;
  logic wr_en = 0, wr_is_mem = 0;
  logic [31:0] wr_addr = 0, wr_data = 0;
  logic [3:0]  wr_be = 0;
  logic m_ready = 0;
  logic m_valid, err_proto, err_timeout;
  logic [31:0] m_data, credit_reg, data_reg;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] last_acc = 0;

  always #4 clk = ~clk;

  credit_sink #(
    .ADDR_W(32), .BAR_BASE(64'h8000_0000), .BAR_LOG2(20),
    .PAGE_DWORDS(PAGE), .BUF_PAGES(PAGES), .CLK_HZ(CLKHZ), .TIMEOUT_MS(TMO_MS)
  ) i_credit_sink (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .cfg_mode(cfg_mode),
    .wr_en(wr_en), .wr_is_mem(wr_is_mem), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .credit_reg(credit_reg), .data_reg(data_reg), .err_proto(err_proto),
    .err_timeout(err_timeout)
  );

  function automatic logic [31:0] exp_credit(input int unsigned grants);
    return (grants % 256) << 8;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d,
                    input logic [3:0] be, input bit mem);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; wr_be = be; wr_is_mem = mem;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic pop_expect(input logic [31:0] exp, input string req);
    @(negedge clk);
    check(m_valid && m_data == exp, req, m_data, exp);
    m_ready = 1;
    @(posedge clk); #1;
    m_ready = 0;
  endtask

  task automatic ctrl(input bit s, input bit c);
    @(negedge clk); xfer_start = s; cfg_mode = c;
  endtask

  task automatic teardown_and_enable();
    ctrl(0, 0); cyc(2);
    ctrl(1, 1); cyc(3);
  endtask

  // reset state, R7 and R2
  task automatic t_reset();
    cyc(1);
    check(credit_reg == 0, "R2 reset credit", credit_reg, 0);
    check(data_reg == 0, "R7 reset data", data_reg, 0);
    check(!m_valid && !err_proto && !err_timeout, "R9 reset flags",
          {m_valid, err_proto, err_timeout}, 0);
  endtask

  // R10 inactive writes, R1 first credit, R5 ignored writes
  task automatic t_enable_and_ignore();
    wr(IN_A, 32'hDEAD0001, 4'hF, 1);
    cyc(2);
    check(!m_valid && !err_proto && credit_reg == 0, "R10 inactive write",
          {m_valid, err_proto, credit_reg[29:0]}, 0);
    ctrl(1, 0); cyc(3);
    check(credit_reg == 0, "R10 half-enabled no credit", credit_reg, 0);
    ctrl(1, 1); cyc(2);
    check(credit_reg == exp_credit(1), "R1 first credit", credit_reg, exp_credit(1));
    wr(IN_A, 32'hC0F16001, 4'hF, 0);
    wr(OUT_A, 32'hC0F16002, 4'hF, 1);
    cyc(2);
    check(!m_valid && !err_proto, "R5 cfg/out-of-window ignored",
          {m_valid, err_proto}, 0);
    check(data_reg == 0, "R5 data_reg untouched", data_reg, 0);
  endtask

  // R3, R4, R6, R7 page accounting with stalled consumer
  task automatic t_pages();
    for (int k = 0; k < PAGE; k++) wr(IN_A + 32'(4*k), 32'h1000 + 32'(k), 4'hF, 1);
    cyc(2);
    check(credit_reg == exp_credit(2), "R3 second credit after page", credit_reg,
          exp_credit(2));
    for (int k = 0; k < PAGE; k++) wr(IN_A, 32'h2000 + 32'(k), 4'hF, 1);
    last_acc = 32'h2000 + 32'(PAGE - 1);
    cyc(3);
    check(credit_reg == exp_credit(2), "R3 no credit while buffer full", credit_reg,
          exp_credit(2));
    check(data_reg == last_acc, "R7 last accepted dword", data_reg, last_acc);
    check(m_valid && m_data == 32'h1000, "R4 head of stream", m_data, 32'h1000);
    cyc(4);
    check(m_valid && m_data == 32'h1000, "R4 hold while stalled", m_data, 32'h1000);
    wr(IN_A, 32'hBAD00001, 4'hF, 1);
    cyc(1);
    check(err_proto == 1, "R6 write without credit", {31'b0, err_proto}, 1);
    check(data_reg == last_acc, "R6 dropped data", data_reg, last_acc);
    for (int k = 0; k < PAGE; k++) pop_expect(32'h1000 + 32'(k), "R4 order page0");
    cyc(2);
    check(credit_reg == exp_credit(3), "R3 credit after drain", credit_reg,
          exp_credit(3));
    for (int k = 0; k < PAGE; k++) pop_expect(32'h2000 + 32'(k), "R4 order page1");
    cyc(1);
    check(!m_valid, "R4 empty after drain", {31'b0, m_valid}, 0);
  endtask

  // R9 teardown clears, R6 partial enables
  task automatic t_partial();
    ctrl(0, 0); cyc(2);
    check(credit_reg == 0 && !err_proto, "R9 teardown clears",
          {credit_reg[30:0], err_proto}, 0);
    ctrl(1, 1); cyc(3);
    check(credit_reg == exp_credit(1), "R9 count restarts", credit_reg, exp_credit(1));
    wr(IN_A, 32'hBAD00002, 4'h7, 1);
    cyc(1);
    check(err_proto == 1, "R6 partial byte enables", {31'b0, err_proto}, 1);
    check(!m_valid && data_reg == last_acc, "R6 partial dropped", data_reg, last_acc);
  endtask

  // R8 starvation window
  task automatic t_timeout();
    teardown_and_enable();
    for (int k = 0; k < 3; k++) wr(IN_A, 32'h3000 + 32'(k), 4'hF, 1);
    m_ready = 1;
    cyc(150);
    check(err_timeout == 0, "R8 no failure inside window", {31'b0, err_timeout}, 0);
    cyc(80);
    check(err_timeout == 1, "R8 failure after window", {31'b0, err_timeout}, 1);
    wr(IN_A, 32'h3003, 4'hF, 1);
    cyc(1);
    check(err_proto == 1, "R8 credit withdrawn", {31'b0, err_proto}, 1);
    cyc(20);
    check(credit_reg == exp_credit(1), "R8 no new credit", credit_reg, exp_credit(1));
    ctrl(0, 0); cyc(2);
    check(!err_timeout, "R9 teardown clears failure", {31'b0, err_timeout}, 0);
  endtask

  // R2 wrap of the exposed total, consumer always ready
  task automatic t_wrap();
    ctrl(1, 1); cyc(3);
    m_ready = 1;
    for (int p = 0; p < 256; p++) begin
      for (int k = 0; k < PAGE; k++) wr(IN_A, 32'(p * 16 + k), 4'hF, 1);
      cyc(2);
      if (p == 254)
        check(credit_reg == exp_credit(256), "R2 total 256 reads zero", credit_reg,
              exp_credit(256));
    end
    check(credit_reg == exp_credit(257), "R2 total wraps", credit_reg, exp_credit(257));
    check(!err_proto && !err_timeout, "R1 clean paced run",
          {err_proto, err_timeout}, 0);
    m_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog act=hang exp=finish");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_enable_and_ignore();
    t_pages();
    t_partial();
    t_timeout();
    t_wrap();
    done = 1;
    summary();
    $finish;
  end

endmodule